// File: doc/BRIEF.md
# Dual-Range Reference Clock Divider

This block turns a reference oscillator clock into the comparison rate of a synthesizer loop. On each terminal count it emits a one-cycle pulse. It then reloads and begins the next comparison period. The division ratio comes from a 15-bit ratio word and a range bit, and both are captured on a load strobe.

The range bit selects one of two paths. In the coarse range, a divide-by-8 prescaler feeds a 13-bit programmable counter, so the division steps in multiples of eight. In the fine range, the prescaler is bypassed and a 15-bit counter runs directly on the oscillator, giving unit steps. Every counter is synchronous to the oscillator clock. A captured setting waits in a holding register and goes live only at the next terminal count, so no comparison period is ever cut short.

Top module: `ref_divider`

## Requirements
- R1: While `rstN` is low, `frPulse` is low. Reset selects the coarse range with a ratio of 5, so the first pulse appears exactly 40 oscillator cycles after reset is released, and the pulses then repeat every 40 cycles.
- R2: In the coarse range (`modeFine` = 0 at the load strobe), the pulse period is 8 times the value of `ratioWord[12:0]`. Bits 14 and 13 of the ratio word have no effect in this range.
- R3: In the fine range (`modeFine` = 1 at the load strobe), the pulse period equals the full 15-bit value of `ratioWord`, up to 32767.
- R4: A ratio value below 5 is treated as 5 in either range. The resulting period is 40 cycles in the coarse range and 5 cycles in the fine range.
- R5: `frPulse` is high for exactly one oscillator cycle per period.
- R6: A setting captured by `loadStrobe` does not change the period in progress. That period completes at its old length, and the new setting governs every period after it.
- R7: If a load strobe is sampled on the same clock edge as a terminal count, the period that starts at that edge still uses the previous setting. The new setting begins at the following terminal count.
- R8: While `loadStrobe` is low, changes on `modeFine` and `ratioWord` have no effect on the pulse period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| oscClk | input | 1 | Reference oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeFine | input | 1 | Range select captured on load: 0 coarse (x8), 1 fine (x1) |
| ratioWord | input | 15 | Programmed ratio value captured on load |
| loadStrobe | input | 1 | Captures `modeFine` and `ratioWord` into the holding register |
| frPulse | output | 1 | One-cycle pulse at each terminal count |

## Verification
A load strobe and a terminal count can land on the same oscillator edge. In that case the holding register is written while its previous contents are copied into the live setting. The bench provokes this by measuring the current period, counting forward from a pulse to the edge of the next terminal count, and raising the strobe for exactly that edge. It confirms the coincidence by seeing the pulse in the following cycle. It then requires one more period at the old length before the new length appears. A strobe in mid-period is checked the same way: the partly elapsed period must still end at its old length.

// File: rtl/ref_divider_pkg.sv
package ref_divider_pkg;

  // Per-cycle strobes from control to datapath.
  typedef struct packed {
    logic tick;      // counter advance enable (prescaler output or every cycle)
    logic fineMode;  // live range selection
  } div_strobes_t;

endpackage

// File: rtl/ref_divider_ctrl.sv
module ref_divider_ctrl
  import ref_divider_pkg::*;
#(
  parameter int RATIO_W   = 15,
  parameter int COARSE_W  = 13,
  parameter int PRE_BITS  = 3,
  parameter int MIN_RATIO = 5
) (
  input  logic               oscClk,
  input  logic               rstN,
  input  logic               modeFine,
  input  logic [RATIO_W-1:0] ratioWord,
  input  logic               loadStrobe,
  input  logic               termCount,
  output div_strobes_t       strobes,
  output logic [RATIO_W-1:0] reloadVal
);

  localparam int PRE_MAX = (1 << PRE_BITS) - 1;
  localparam logic [RATIO_W-1:0] MIN_VAL = RATIO_W'(MIN_RATIO);

  logic [RATIO_W-1:0]  rawVal;
  logic [RATIO_W-1:0]  clampVal;
  logic [RATIO_W-1:0]  pendRatio;
  logic                pendFine;
  logic                liveFine;
  logic [PRE_BITS-1:0] preCnt;

  // Coarse range keeps only the low COARSE_W bits of the ratio word.
  generate
    if (COARSE_W < RATIO_W) begin : g_coarseMask
      always_comb begin
        if (modeFine) rawVal = ratioWord;
        else          rawVal = {{(RATIO_W-COARSE_W){1'b0}}, ratioWord[COARSE_W-1:0]};
      end
    end else begin : g_fullWidth
      always_comb rawVal = ratioWord;
    end
  endgenerate

  always_comb clampVal = (rawVal < MIN_VAL) ? MIN_VAL : rawVal;

  // Holding register: written by the strobe only.
  always_ff @(posedge oscClk or negedge rstN) begin
    if (!rstN) begin
      pendRatio <= MIN_VAL;
      pendFine  <= 1'b0;
    end else if (loadStrobe) begin
      pendRatio <= clampVal;
      pendFine  <= modeFine;
    end
  end

  // Live range and prescaler: both restart at terminal count.
  always_ff @(posedge oscClk or negedge rstN) begin
    if (!rstN) begin
      liveFine <= 1'b0;
      preCnt   <= '0;
    end else if (termCount) begin
      liveFine <= pendFine;
      preCnt   <= '0;
    end else begin
      preCnt   <= preCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.fineMode = liveFine;
    strobes.tick     = liveFine | (preCnt == PRE_BITS'(PRE_MAX));
    reloadVal        = pendRatio - 1'b1;
  end

endmodule

// File: rtl/ref_divider_dp.sv
module ref_divider_dp
  import ref_divider_pkg::*;
#(
  parameter int RATIO_W   = 15,
  parameter int MIN_RATIO = 5
) (
  input  logic               oscClk,
  input  logic               rstN,
  input  div_strobes_t       strobes,
  input  logic [RATIO_W-1:0] reloadVal,
  output logic               termCount,
  output logic [RATIO_W-1:0] countVal,
  output logic               frPulse
);

  always_comb termCount = strobes.tick && (countVal == '0);

  always_ff @(posedge oscClk or negedge rstN) begin
    if (!rstN) begin
      countVal <= RATIO_W'(MIN_RATIO - 1);
      frPulse  <= 1'b0;
    end else begin
      frPulse <= termCount;
      if (termCount)         countVal <= reloadVal;
      else if (strobes.tick) countVal <= countVal - 1'b1;
    end
  end

endmodule

// File: rtl/ref_divider.sv
module ref_divider
  import ref_divider_pkg::*;
#(
  parameter int RATIO_W   = 15,
  parameter int COARSE_W  = 13,
  parameter int PRE_BITS  = 3,
  parameter int MIN_RATIO = 5
) (
  input  logic               oscClk,
  input  logic               rstN,
  input  logic               modeFine,
  input  logic [RATIO_W-1:0] ratioWord,
  input  logic               loadStrobe,
  output logic               frPulse
);

  div_strobes_t       strobes;
  logic [RATIO_W-1:0] reloadVal;
  logic [RATIO_W-1:0] countVal;
  logic               termCount;

  ref_divider_ctrl #(
    .RATIO_W(RATIO_W), .COARSE_W(COARSE_W),
    .PRE_BITS(PRE_BITS), .MIN_RATIO(MIN_RATIO)
  ) u_ctrl (
    .oscClk(oscClk), .rstN(rstN), .modeFine(modeFine), .ratioWord(ratioWord),
    .loadStrobe(loadStrobe), .termCount(termCount),
    .strobes(strobes), .reloadVal(reloadVal)
  );

  ref_divider_dp #(
    .RATIO_W(RATIO_W), .MIN_RATIO(MIN_RATIO)
  ) u_dp (
    .oscClk(oscClk), .rstN(rstN), .strobes(strobes), .reloadVal(reloadVal),
    .termCount(termCount), .countVal(countVal), .frPulse(frPulse)
  );

endmodule

// File: rtl/ref_divider_chk.sv
module ref_divider_chk
  import ref_divider_pkg::*;
#(
  parameter int RATIO_W   = 15,
  parameter int MIN_RATIO = 5
) (
  input logic               oscClk,
  input logic               rstN,
  input logic               frPulse,
  input logic               termCount,
  input div_strobes_t       strobes,
  input logic [RATIO_W-1:0] reloadVal,
  input logic [RATIO_W-1:0] countVal
);

  // R1: output quiet during reset
  assert_reset_quiet_R1: assert property (@(posedge oscClk) !rstN |-> !frPulse);

  // R5: pulse never lasts two cycles
  assert_single_pulse_R5: assert property (@(posedge oscClk) disable iff (!rstN)
    frPulse |=> !frPulse);

  // R6: live range changes only at terminal count
  assert_range_hold_R6: assert property (@(posedge oscClk) disable iff (!rstN)
    !termCount |=> $stable(strobes.fineMode));

  // R3: fine range steps the counter every cycle
  assert_fine_step_R3: assert property (@(posedge oscClk) disable iff (!rstN)
    (strobes.fineMode && !termCount) |=> (countVal == $past(countVal) - 1'b1));

  // R2: coarse range never advances on two cycles in a row
  assert_coarse_spacing_R2: assert property (@(posedge oscClk) disable iff (!rstN)
    (!strobes.fineMode && strobes.tick && !termCount) |=> !strobes.tick);

  // R4: reload never falls below the minimum ratio
  assert_reload_floor_R4: assert property (@(posedge oscClk) disable iff (!rstN)
    reloadVal >= RATIO_W'(MIN_RATIO - 1));

endmodule

bind ref_divider ref_divider_chk #(.RATIO_W(RATIO_W), .MIN_RATIO(MIN_RATIO)) u_chk (
  .oscClk(oscClk), .rstN(rstN), .frPulse(frPulse), .termCount(termCount),
  .strobes(strobes), .reloadVal(reloadVal), .countVal(countVal)
);

// File: tb/tb_ref_divider.sv
module tb_ref_divider;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        oscClk = 1'b0;
  logic        rstN;
  logic        modeFine;
  logic [14:0] ratioWord;
  logic        loadStrobe;
  logic        frPulse;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit timedOut = 1'b0;

  ref_divider dut (
    .oscClk(oscClk), .rstN(rstN), .modeFine(modeFine), .ratioWord(ratioWord),
    .loadStrobe(loadStrobe), .frPulse(frPulse)
  );

  always #(CLK_PERIOD/2) oscClk = ~oscClk;
  always @(posedge oscClk) cycles <= cycles + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expPeriod(input bit fine, input int val);
    int v;
    v = fine ? (val & 32'h7fff) : (val & 32'h1fff);
    if (v < 5) v = 5;
    return fine ? v : 8 * v;
  endfunction

  // Advance at least one negedge, stop at the first one that sees a pulse.
  task automatic waitPulse();
    do begin
      @(negedge oscClk);
    end while (!frPulse && !timedOut);
  endtask

  // From a pulse negedge, count negedges to the next pulse; also checks width.
  task automatic measure(output int p);
    p = 0;
    do begin
      @(negedge oscClk);
      p++;
      if (p == 1) check(!frPulse, "R5", int'(frPulse), 0);
    end while (!frPulse && !timedOut);
  endtask

  task automatic strobeAt(input bit fine, input int val);
    modeFine   = fine;
    ratioWord  = val[14:0];
    loadStrobe = 1'b1;
    @(negedge oscClk);
    loadStrobe = 1'b0;
  endtask

  // Load at a pulse, wait for it to apply, then measure the new period.
  task automatic loadAndCheck(input bit fine, input int val, input string req);
    int p;
    waitPulse();
    strobeAt(fine, val);
    waitPulse();
    measure(p);
    check(p == expPeriod(fine, val), req, p, expPeriod(fine, val));
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    timedOut = 1'b1;
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p;
    int n;
    rstN = 1'b0; modeFine = 1'b0; ratioWord = '0; loadStrobe = 1'b0;
    repeat (3) @(negedge oscClk);
    check(!frPulse, "R1 reset", int'(frPulse), 0);
    rstN = 1'b1;

    // R1: first pulse 40 cycles after release, then period 40
    n = 0;
    do begin @(negedge oscClk); n++; end while (!frPulse);
    check(n == 40, "R1 first", n, 40);
    measure(p);
    check(p == 40, "R1 period", p, 40);

    // R3: fine range sweep
    for (int v = 5; v <= 40; v++) loadAndCheck(1'b1, v, "R3");
    loadAndCheck(1'b1, 4000, "R3");

    // R2: coarse range sweep, plus ignored upper bits
    for (int v = 5; v <= 16; v++) loadAndCheck(1'b0, v, "R2");
    loadAndCheck(1'b0, 1000, "R2");
    loadAndCheck(1'b0, 15'h6007, "R2 upper bits");

    // R4: clamp in both ranges
    for (int v = 0; v < 5; v++) begin
      loadAndCheck(1'b1, v, "R4 fine");
      loadAndCheck(1'b0, v, "R4 coarse");
    end

    // R8: inputs change without strobe
    loadAndCheck(1'b1, 9, "R8 setup");
    modeFine = 1'b0; ratioWord = 15'd30;
    measure(p);
    check(p == 9, "R8", p, 9);
    measure(p);
    check(p == 9, "R8", p, 9);

    // R6: mid-period load keeps the running period
    loadAndCheck(1'b1, 11, "R6 setup");
    strobeAt(1'b1, 23);
    n = 1;
    while (!frPulse) begin @(negedge oscClk); n++; end
    check(n == 11, "R6 old", n, 11);
    measure(p);
    check(p == 23, "R6 new", p, 23);

    // R6: range change from fine to coarse also deferred
    strobeAt(1'b0, 6);
    n = 1;
    while (!frPulse) begin @(negedge oscClk); n++; end
    check(n == 23, "R6 range old", n, 23);
    measure(p);
    check(p == 48, "R6 range new", p, 48);

    // R7: strobe on the terminal-count edge
    loadAndCheck(1'b1, 13, "R7 setup");
    repeat (12) @(negedge oscClk);
    strobeAt(1'b1, 7);
    check(frPulse, "R7 coincide", int'(frPulse), 1);
    measure(p);
    check(p == 13, "R7 old", p, 13);
    measure(p);
    check(p == 7, "R7 new", p, 7);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule